// File: doc/BRIEF.md
# Banked Register Window with Indirect Packet-Memory Port

This block sits between a host bus and a packet buffer. The host sees sixteen byte-wide register offsets. One offset holds a bank number that chooses what the other offsets mean. In the data bank there is a 16-bit pointer and a four-byte data window. Every host access to the data window becomes one byte request to packet memory. The request carries a page number, an 11-bit byte address and a data byte.

The pointer controls the request. Its top bit picks the source page: either the page at the head of the receive queue or the page named by the packet-number input. Another bit turns on auto-increment. With auto-increment on, each data byte steps the byte address. With it off, the address is the pointer offset plus the byte position inside the window.

A host access may be 8, 16 or 32 bits wide. The access sequencer turns it into byte beats, one per clock, lowest lane first. It then returns the assembled read data with a one-cycle done pulse. The sequencer has three states:
- `ST_IDLE` (ready). Accepting an access takes it to `ST_BEAT`.
- `ST_BEAT` (one byte per cycle). It stays there until the last lane, then moves to `ST_RESP`.
- `ST_RESP` (done pulse). It always returns to `ST_IDLE`.

Top module: `ptr_window`

## Requirements
- R1: Offset 14 holds the bank number as a full byte in every bank: a write stores it, a read returns it, and it resets to 0. The data bank is bank 2.
- R2: Offset 15 reads 0x33 in every bank. A write to offset 15 changes no state.
- R3: A data-window access (bank 2, offsets 8 to 11) requests the page `rxq_head_page` when pointer bit 15 is 1, and the page `pkt_num_page` when it is 0.
- R4: When pointer bit 14 is 1, the byte address of each data beat is pointer bits 10:0. After the beat, bits 10:0 increment, wrapping from 0x7FF to 0x000, and bits 15:11 stay unchanged.
- R5: When pointer bit 14 is 0, the byte address is pointer bits 10:0 plus the low two bits of the beat's offset, modulo 2048. The pointer is not changed.
- R6: In bank 2, offset 6 is the pointer low byte and offset 7 is the pointer high byte. Both can be written. Reading offset 6 returns the low byte exactly. Reading offset 7 returns the high byte with bit 3 forced to 0 (mask 0xF7).
- R7: `acc_size` encodes the width: 0 is a byte, 1 is 16 bits, 2 is 32 bits, and 3 acts as a byte. An access of N bytes becomes N beats in N consecutive cycles. Lane k goes to offset `acc_offset`+k (mod 16), and data lane k is bits 8k+7:8k. No memory request is made outside a beat.
- R8: A 32-bit access at offset 12 makes only two beats, on lanes 2 and 3 (offsets 14 and 15). Read lanes 0 and 1 return zero.
- R9: Every offset not named above, and offsets 6 to 11 outside bank 2, reads 0. A write to any of them changes no state and makes no memory request.
- R10: After reset the pointer is 0, the bank is 0, `acc_ready` is 1, and `mem_req` and `acc_done` are 0.
- R11: `acc_done` is high for exactly one cycle, the cycle after the last beat. `acc_rdata` then holds the read bytes in their lanes, and is 0 after a write. `acc_ready` is low from acceptance until after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request, taken when acc_ready is high |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 half word, 2 word |
| acc_offset | input | 4 | Starting register offset |
| acc_wdata | input | 32 | Write data, lane k at bits 8k+7:8k |
| acc_ready | output | 1 | Sequencer idle |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 32 | Assembled read data |
| rxq_head_page | input | PAGE_W | Page at head of the receive queue |
| pkt_num_page | input | PAGE_W | Page from the packet-number register |
| mem_req | output | 1 | Packet-memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_page | output | PAGE_W | Requested page |
| mem_addr | output | ADDR_W | Byte address inside the page |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte for the current request (same cycle) |

## Verification
Two functions can land on back-to-back beats of a single access: a pointer byte update and the data beat that depends on it. A 16-bit pointer write followed by a 32-bit data access checks that the first data beat uses the pointer just written. After a bank write through offset 14, the next access has to decode under the new bank. In the 32-bit access at offset 12, a bank write shares the access with the fixed-value beat at offset 15. A scoreboard tracks the bank and pointer as separate state. It judges every memory request by page, address, direction and byte, and every completion by its data and by the number of cycles it took.

// File: rtl/ptrwin_pkg.sv
package ptrwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_RESP
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK,
        SEL_ID,
        SEL_PTR_LO,
        SEL_PTR_HI,
        SEL_DATA
    } win_sel_e;

    localparam logic [1:0] SZ_HALF        = 2'd1;
    localparam logic [1:0] SZ_WORD        = 2'd2;
    localparam logic [3:0] OFF_BANK       = 4'd14;
    localparam logic [3:0] OFF_ID         = 4'd15;
    localparam logic [3:0] OFF_PTR_LO     = 4'd6;
    localparam logic [3:0] OFF_PTR_HI     = 4'd7;
    localparam logic [3:0] OFF_SPLIT      = 4'd12;
    localparam logic [7:0] ID_BYTE        = 8'h33;
    localparam logic [7:0] DATA_BANK      = 8'd2;
    localparam logic [7:0] PTR_HI_RDMASK  = 8'hF7;
    localparam int         PTR_SRC_BIT    = 15;
    localparam int         PTR_INC_BIT    = 14;

endpackage

// File: rtl/ptrwin_seq.sv
module ptrwin_seq
    import ptrwin_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int DW = 8 * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [3:0]    acc_offset,
    input  logic [DW-1:0] acc_wdata,
    input  logic [7:0]    beat_rbyte,
    output logic          acc_ready,
    output logic          acc_done,
    output logic [DW-1:0] acc_rdata,
    output logic          beat_act,
    output logic          beat_write,
    output logic [3:0]    beat_off,
    output logic [7:0]    beat_wbyte
);

    seq_state_e         st_q, st_d;
    logic [LANE_W-1:0]  lane_q, last_q;
    logic [LANE_W-1:0]  first_lane, last_lane;
    logic [3:0]         base_q;
    logic               wr_q;
    logic [DW-1:0]      wdata_q;
    logic               accept;
    logic               last_beat;

    assign accept    = (st_q == ST_IDLE) && acc_valid;
    assign last_beat = (lane_q == last_q);

    always_comb begin
        first_lane = '0;
        if (acc_size == SZ_WORD && acc_offset == OFF_SPLIT)
            first_lane = LANE_W'(LANES / 2);
        last_lane = '0;
        if (acc_size == SZ_HALF)
            last_lane = LANE_W'(1);
        else if (acc_size == SZ_WORD)
            last_lane = LANE_W'(LANES - 1);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (acc_valid) st_d = ST_BEAT;
            ST_BEAT: if (last_beat) st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q  <= '0;
            last_q  <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            lane_q  <= first_lane;
            last_q  <= last_lane;
            base_q  <= acc_offset;
            wr_q    <= acc_write;
            wdata_q <= acc_wdata;
        end else if (st_q == ST_BEAT && !last_beat) begin
            lane_q  <= lane_q + LANE_W'(1);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] rd_byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n || accept)
                rd_byte_q <= '0;
            else if (st_q == ST_BEAT && !wr_q && lane_q == LANE_W'(g))
                rd_byte_q <= beat_rbyte;
        end
        assign acc_rdata[g*8 +: 8] = rd_byte_q;
    end

    always_comb begin
        acc_ready  = (st_q == ST_IDLE);
        beat_act   = (st_q == ST_BEAT);
        acc_done   = (st_q == ST_RESP);
        beat_write = wr_q;
        beat_off   = base_q + 4'(lane_q);
        beat_wbyte = wdata_q[lane_q*8 +: 8];
    end

endmodule

// File: rtl/ptrwin_decode.sv
module ptrwin_decode
    import ptrwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat_act,
    input  logic        beat_write,
    input  logic [3:0]  beat_off,
    input  logic [7:0]  beat_wbyte,
    input  logic [15:0] ptr_q,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  bank_q,
    output logic [7:0]  beat_rbyte,
    output logic        ptr_lo_we,
    output logic        ptr_hi_we,
    output logic        data_act
);

    win_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (beat_off == OFF_BANK)
            sel = SEL_BANK;
        else if (beat_off == OFF_ID)
            sel = SEL_ID;
        else if (bank_q == DATA_BANK) begin
            if (beat_off == OFF_PTR_LO)
                sel = SEL_PTR_LO;
            else if (beat_off == OFF_PTR_HI)
                sel = SEL_PTR_HI;
            else if (beat_off[3:2] == 2'b10)
                sel = SEL_DATA;
        end
    end

    always_comb begin
        beat_rbyte = '0;
        unique case (sel)
            SEL_BANK:   beat_rbyte = bank_q;
            SEL_ID:     beat_rbyte = ID_BYTE;
            SEL_PTR_LO: beat_rbyte = ptr_q[7:0];
            SEL_PTR_HI: beat_rbyte = ptr_q[15:8] & PTR_HI_RDMASK;
            SEL_DATA:   beat_rbyte = mem_rdata;
            default:    beat_rbyte = '0;
        endcase
        ptr_lo_we = beat_act && beat_write && (sel == SEL_PTR_LO);
        ptr_hi_we = beat_act && beat_write && (sel == SEL_PTR_HI);
        data_act  = beat_act && (sel == SEL_DATA);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (beat_act && beat_write && sel == SEL_BANK)
            bank_q <= beat_wbyte;
    end

endmodule

// File: rtl/ptrwin_ptr.sv
module ptrwin_ptr
    import ptrwin_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_lo_we,
    input  logic              ptr_hi_we,
    input  logic [7:0]        wbyte,
    input  logic              data_act,
    input  logic [1:0]        lane_off,
    input  logic [PAGE_W-1:0] rxq_head_page,
    input  logic [PAGE_W-1:0] pkt_num_page,
    output logic [15:0]       ptr_q,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] offs;
    logic              auto_inc;

    assign offs     = ptr_q[ADDR_W-1:0];
    assign auto_inc = ptr_q[PTR_INC_BIT];

    always_comb begin
        mem_page = ptr_q[PTR_SRC_BIT] ? rxq_head_page : pkt_num_page;
        if (auto_inc)
            mem_addr = offs;
        else
            mem_addr = offs + ADDR_W'(lane_off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_lo_we)
            ptr_q[7:0] <= wbyte;
        else if (ptr_hi_we)
            ptr_q[15:8] <= wbyte;
        else if (data_act && auto_inc)
            ptr_q[ADDR_W-1:0] <= offs + ADDR_W'(1);
    end

endmodule

// File: rtl/ptr_window.sv
module ptr_window
    import ptrwin_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PAGE_W    = $clog2(PAGES),
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [3:0]        acc_offset,
    input  logic [31:0]       acc_wdata,
    output logic              acc_ready,
    output logic              acc_done,
    output logic [31:0]       acc_rdata,
    input  logic [PAGE_W-1:0] rxq_head_page,
    input  logic [PAGE_W-1:0] pkt_num_page,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic        beat_act, beat_write;
    logic [3:0]  beat_off;
    logic [7:0]  beat_wbyte, beat_rbyte;
    logic [7:0]  bank_q;
    logic [15:0] ptr_q;
    logic        ptr_lo_we, ptr_hi_we, data_act;

    ptrwin_seq #(.LANES(4)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_size   (acc_size),
        .acc_offset (acc_offset),
        .acc_wdata  (acc_wdata),
        .beat_rbyte (beat_rbyte),
        .acc_ready  (acc_ready),
        .acc_done   (acc_done),
        .acc_rdata  (acc_rdata),
        .beat_act   (beat_act),
        .beat_write (beat_write),
        .beat_off   (beat_off),
        .beat_wbyte (beat_wbyte)
    );

    ptrwin_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_act   (beat_act),
        .beat_write (beat_write),
        .beat_off   (beat_off),
        .beat_wbyte (beat_wbyte),
        .ptr_q      (ptr_q),
        .mem_rdata  (mem_rdata),
        .bank_q     (bank_q),
        .beat_rbyte (beat_rbyte),
        .ptr_lo_we  (ptr_lo_we),
        .ptr_hi_we  (ptr_hi_we),
        .data_act   (data_act)
    );

    ptrwin_ptr #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .ptr_lo_we     (ptr_lo_we),
        .ptr_hi_we     (ptr_hi_we),
        .wbyte         (beat_wbyte),
        .data_act      (data_act),
        .lane_off      (beat_off[1:0]),
        .rxq_head_page (rxq_head_page),
        .pkt_num_page  (pkt_num_page),
        .ptr_q         (ptr_q),
        .mem_page      (mem_page),
        .mem_addr      (mem_addr)
    );

    assign mem_req   = data_act;
    assign mem_we    = data_act && beat_write;
    assign mem_wdata = beat_wbyte;

endmodule

// File: rtl/ptrwin_chk.sv
module ptrwin_chk #(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_ready,
    input logic              acc_done,
    input logic              mem_req,
    input logic [15:0]       ptr_q,
    input logic [PAGE_W-1:0] mem_page,
    input logic [PAGE_W-1:0] rxq_head_page,
    input logic [PAGE_W-1:0] pkt_num_page
);

    AST_PAGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_page == (ptr_q[15] ? rxq_head_page : pkt_num_page)); // R3

    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ptr_q[14]) |=> ptr_q[10:0] == $past(ptr_q[10:0]) + 11'd1); // R4

    AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> ptr_q[15:11] == $past(ptr_q[15:11])); // R4

    AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ptr_q[14]) |=> $stable(ptr_q)); // R5

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> !mem_req); // R7

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done); // R11

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> !acc_ready); // R11

endmodule

bind ptr_window ptrwin_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_ready     (acc_ready),
    .acc_done      (acc_done),
    .mem_req       (mem_req),
    .ptr_q         (ptr_q),
    .mem_page      (mem_page),
    .rxq_head_page (rxq_head_page),
    .pkt_num_page  (pkt_num_page)
);

// File: tb/sim_ptr_window.sv
`timescale 1ns/1ps
module sim_ptr_window;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 11;
    localparam int MEM_N = 4 * 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_size = '0;
    logic [3:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic acc_ready, acc_done;
    logic [31:0] acc_rdata;
    logic [PAGE_W-1:0] rxq_head_page = 2'd3;
    logic [PAGE_W-1:0] pkt_num_page = 2'd1;
    logic mem_req, mem_we;
    logic [PAGE_W-1:0] mem_page;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_window u0 (.*);

    logic [7:0] bmem [MEM_N];
    assign mem_rdata = bmem[{mem_page, mem_addr}];
    always @(posedge clk) if (mem_req && mem_we) bmem[{mem_page, mem_addr}] <= mem_wdata;

    typedef struct {
        logic              we;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        string             tag;
    } mexp_t;

    mexp_t mq[$];
    logic [31:0] rq[$];
    string rtag[$];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] m_bank = 8'd0;
    logic [15:0] m_ptr = 16'd0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                if (mq.size() == 0) begin
                    chk(0, "R9 unexpected memory request", {21'd0, mem_addr}, 32'd0);
                end else begin
                    mexp_t e;
                    e = mq.pop_front();
                    chk(mem_we == e.we, {e.tag, " direction"}, 32'(mem_we), 32'(e.we));
                    chk(mem_page == e.page, {e.tag, " page"}, 32'(mem_page), 32'(e.page));
                    chk(mem_addr == e.addr, {e.tag, " address"}, 32'(mem_addr), 32'(e.addr));
                    if (e.we) chk(mem_wdata == e.wdata, {e.tag, " wbyte"}, 32'(mem_wdata), 32'(e.wdata));
                end
            end
            if (acc_done) begin
                if (rq.size() == 0) begin
                    chk(0, "R11 unexpected done", acc_rdata, 32'd0);
                end else begin
                    logic [31:0] x;
                    string t;
                    x = rq.pop_front();
                    t = rtag.pop_front();
                    chk(acc_rdata == x, {t, " rdata"}, acc_rdata, x);
                end
            end
        end
    end

    task automatic model_byte(input bit wr, input logic [3:0] off, input logic [7:0] wb,
                              output logic [7:0] rb, input string tag);
        rb = 8'd0;
        if (off == 4'd14) begin
            if (wr) m_bank = wb; else rb = m_bank;
        end else if (off == 4'd15) begin
            rb = 8'h33;
        end else if (m_bank == 8'd2) begin
            if (off == 4'd6) begin
                if (wr) m_ptr[7:0] = wb; else rb = m_ptr[7:0];
            end else if (off == 4'd7) begin
                if (wr) m_ptr[15:8] = wb; else rb = m_ptr[15:8] & 8'hF7;
            end else if (off >= 4'd8 && off <= 4'd11) begin
                mexp_t e;
                e.we = wr;
                e.page = m_ptr[15] ? rxq_head_page : pkt_num_page;
                e.addr = m_ptr[14] ? m_ptr[10:0] : m_ptr[10:0] + 11'(off[1:0]);
                e.wdata = wb;
                e.tag = tag;
                mq.push_back(e);
                if (!wr) rb = bmem[{e.page, e.addr}];
                if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
            end
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [3:0] off,
                          input logic [31:0] wd, input string tag);
        int first, last, lat;
        logic [31:0] exp;
        logic [7:0] rb;
        first = (sz == 2'd2 && off == 4'd12) ? 2 : 0;
        last = (sz == 2'd1) ? 1 : (sz == 2'd2) ? 3 : 0;
        exp = 32'd0;
        for (int k = first; k <= last; k++) begin
            model_byte(wr, off + 4'(k), wd[k*8 +: 8], rb, tag);
            if (!wr) exp[k*8 +: 8] = rb;
        end
        rq.push_back(exp);
        rtag.push_back(tag);
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_offset = off; acc_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        lat = 0;
        while (!acc_done) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(lat == last - first + 1, {tag, " R7 beat count"}, 32'(lat), 32'(last - first + 1));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) bmem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_ready == 1'b1, "R10 ready after reset", 32'(acc_ready), 32'd1);
        chk(mem_req == 1'b0, "R10 no request after reset", 32'(mem_req), 32'd0);
        chk(acc_done == 1'b0, "R10 no done after reset", 32'(acc_done), 32'd0);

        access(0, 2'd0, 4'd14, 0, "R1 bank reset value");
        access(0, 2'd0, 4'd15, 0, "R2 fixed byte");
        access(1, 2'd0, 4'd14, 32'h2, "R1 bank write");
        access(0, 2'd1, 4'd14, 0, "R7 half read across 14/15");
        access(1, 2'd0, 4'd15, 32'h55, "R2 write ignored");
        access(0, 2'd0, 4'd14, 0, "R2 bank kept");
        access(1, 2'd1, 4'd6, 32'h4810, "R6 pointer write");
        access(0, 2'd1, 4'd6, 0, "R6 pointer read masked");
        access(1, 2'd2, 4'd8, 32'hA1B2C3D4, "R4 autoinc write");
        access(0, 2'd1, 4'd6, 0, "R4 pointer after autoinc");
        access(1, 2'd1, 4'd6, 32'hC7FE, "R4 pointer near wrap");
        access(1, 2'd2, 4'd8, 32'h11223344, "R3 rx page wrap write");
        access(0, 2'd1, 4'd6, 0, "R4 high bits held");
        access(0, 2'd2, 4'd8, 0, "R3 rx page read");
        access(1, 2'd3, 4'd10, 32'h9C, "R7 size 3 as byte");
        access(1, 2'd1, 4'd6, 32'h07FF, "R5 fixed pointer");
        access(0, 2'd1, 4'd10, 0, "R5 offset add wrap");
        access(0, 2'd0, 4'd9, 0, "R5 offset add single");
        access(0, 2'd1, 4'd6, 0, "R5 pointer unchanged");
        access(1, 2'd2, 4'd12, 32'h0001BEEF, "R8 split word write");
        access(0, 2'd2, 4'd12, 0, "R8 split word read");
        access(0, 2'd1, 4'd6, 0, "R9 pointer hidden in bank 1");
        access(1, 2'd1, 4'd6, 32'h1234, "R9 write in bank 1");
        access(0, 2'd2, 4'd8, 0, "R9 data window off bank");
        access(1, 2'd0, 4'd14, 32'h2, "R1 back to data bank");
        access(0, 2'd1, 4'd6, 0, "R9 pointer unchanged");
        access(1, 2'd1, 4'd12, 32'hFFFF, "R9 reserved write");
        access(0, 2'd2, 4'd0, 0, "R9 unimplemented read");
        access(0, 2'd0, 4'd14, 0, "R9 bank unchanged");

        repeat (3) @(negedge clk);
        chk(mq.size() == 0, "R7 all requests seen", 32'(mq.size()), 32'd0);
        chk(rq.size() == 0, "R11 all completions seen", 32'(rq.size()), 32'd0);
        summary();
    end

endmodule